// File: doc/BRIEF.md
# Register Window Save/Restore Sequencer with Write Tracking

This block moves one register window between the register file and memory, and transfers only the registers that were actually written. For every window it keeps a 16-bit record of which tracked registers were modified since the window was last entered. Entering a subroutine clears the record for that window. Every register write that the block observes on its snoop input marks the matching bit.

A save first stores the record as a header word at the frame base. It then stores only the marked registers, each into its own fixed slot after the header. A restore reverses this. It loads the header first and installs it as the window's record. It then loads only the marked slots and writes each value back into the register file.

Memory traffic uses a single valid/ready request port with a separate load response. At most one load is outstanding at a time. A one-cycle done pulse marks the end of each command.

Top module: `winsave_seq`

## Requirements
- R1: An entry pulse for a window clears that window's record. A save issued after it stores a header of 0 and no registers.
- R2: Each window has its own record. Architectural indices 24..31 (ins) map to record bits 0..7, and indices 16..23 (locals) map to bits 8..15. A snooped write to a tracked index sets that window's bit. A snooped write to an index below 16 (globals, outs) sets nothing. If an entry and a write hit the same window in the same cycle, the record ends up holding only the written bit.
- R3: The first request of a save is a store to the frame base. Its data is the record, in bits 15:0 of the word, with the upper bits zero.
- R4: After the header, a save stores exactly the marked registers, in ascending bit order. Bit t goes to address base+1+t, with the value read from the register file. Unmarked slots receive no store.
- R5: A request keeps valid, address and direction unchanged until ready is seen.
- R6: A restore first issues a load of the frame base. It then issues loads only for the bits set in the returned header, in ascending order, at base+1+t.
- R7: Each restored slot's response is written to the register file at the window and architectural index of that bit. Registers whose bit is clear, and untracked registers, get no write.
- R8: A restore installs the loaded header as the window's record, so a later save of that window reproduces it.
- R9: Done is high for exactly one cycle. It appears in the cycle after the last store is accepted or the last load response arrives. A save with an all-zero record finishes after the single header store. A restore with a zero header finishes after the single header load.
- R10: A command presented while a command is in progress is ignored.
- R11: After reset, the block is not busy, done is low, no request is pending, and every record is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_en | input | 1 | Subroutine entry: clear the record of enter_win |
| enter_win | input | WIN_W | Window being entered |
| wr_en | input | 1 | Snooped register-file write |
| wr_win | input | WIN_W | Window of the snooped write |
| wr_idx | input | 5 | Architectural index of the snooped write |
| cmd_valid | input | 1 | Start a command (taken only when idle) |
| cmd_save | input | 1 | 1 = save, 0 = restore |
| cmd_win | input | WIN_W | Window to save or restore |
| cmd_base | input | AW | Frame base address (word address) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_rd_win | output | WIN_W | Register-file read window for saves |
| rf_rd_idx | output | 5 | Register-file read index for saves |
| rf_rd_data | input | DW | Register-file read data |
| rf_we | output | 1 | Register-file write strobe for restores |
| rf_wwin | output | WIN_W | Write window |
| rf_widx | output | 5 | Write architectural index |
| rf_wdata | output | DW | Write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = store, 0 = load |
| mem_req_addr | output | AW | Request word address |
| mem_req_wdata | output | DW | Store data |
| mem_rsp_valid | input | 1 | Load response valid |
| mem_rsp_data | input | DW | Load response data |

## Verification
Two kinds of update can reach the same window's record in one cycle: an entry clear and a snooped write. The bench provokes this by driving an entry pulse and a tracked write to one window on the same clock. It then saves that window and expects a header holding only the written bit, followed by a single register store. A second overlap comes from a command arriving while another is still running. The bench pulses a restore one cycle after a save starts, and the scoreboard fails any load it did not predict.

// File: rtl/winsave_pkg.sv
package winsave_pkg;

  localparam int TRACK_N = 16;
  localparam int TRACK_W = 4;
  localparam int ARCH_W  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SV_MAP,
    ST_SV_REG,
    ST_RS_MAP,
    ST_RS_MAPW,
    ST_RS_REG,
    ST_RS_REGW
  } seq_state_t;

  // ins (24..31) -> bits 0..7, locals (16..23) -> bits 8..15
  function automatic logic [TRACK_W-1:0] arch_to_slot(input logic [ARCH_W-1:0] a);
    return a[3] ? {1'b0, a[2:0]} : {1'b1, a[2:0]};
  endfunction

  function automatic logic [ARCH_W-1:0] slot_to_arch(input logic [TRACK_W-1:0] t);
    return t[3] ? {2'b10, t[2:0]} : {2'b11, t[2:0]};
  endfunction

endpackage

// File: rtl/winsave_dirty_map.sv
module winsave_dirty_map
  import winsave_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int WIN_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_en,
  input  logic [WIN_W-1:0]   clr_win,
  input  logic               set_en,
  input  logic [WIN_W-1:0]   set_win,
  input  logic [TRACK_W-1:0] set_slot,
  input  logic               ld_en,
  input  logic [WIN_W-1:0]   ld_win,
  input  logic [TRACK_N-1:0] ld_map,
  input  logic [WIN_W-1:0]   rd_win,
  output logic [TRACK_N-1:0] rd_map
);

  logic [TRACK_N-1:0] maps [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [TRACK_N-1:0] q;
    logic [TRACK_N-1:0] nxt;

    // load, then clear, then set: a write in the entry cycle survives
    always_comb begin
      nxt = q;
      if (ld_en && ld_win == WIN_W'(w))   nxt = ld_map;
      if (clr_en && clr_win == WIN_W'(w)) nxt = '0;
      if (set_en && set_win == WIN_W'(w)) nxt[set_slot] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
    end

    assign maps[w] = q;
  end

  assign rd_map = maps[rd_win];

endmodule

// File: rtl/winsave_pick.sv
module winsave_pick #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] first
);

  always_comb begin
    found = 1'b0;
    first = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        first = W'(i);
      end
    end
  end

endmodule

// File: rtl/winsave_seq.sv
module winsave_seq
  import winsave_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = 16,
  parameter int DW   = 32,
  localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter_en,
  input  logic [WIN_W-1:0]  enter_win,
  input  logic              wr_en,
  input  logic [WIN_W-1:0]  wr_win,
  input  logic [ARCH_W-1:0] wr_idx,
  input  logic              cmd_valid,
  input  logic              cmd_save,
  input  logic [WIN_W-1:0]  cmd_win,
  input  logic [AW-1:0]     cmd_base,
  output logic              busy,
  output logic              done,
  output logic [WIN_W-1:0]  rf_rd_win,
  output logic [ARCH_W-1:0] rf_rd_idx,
  input  logic [DW-1:0]     rf_rd_data,
  output logic              rf_we,
  output logic [WIN_W-1:0]  rf_wwin,
  output logic [ARCH_W-1:0] rf_widx,
  output logic [DW-1:0]     rf_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [AW-1:0]     mem_req_addr,
  output logic [DW-1:0]     mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data
);

  seq_state_t          st_q;
  logic [WIN_W-1:0]    win_q;
  logic [AW-1:0]       base_q;
  logic [TRACK_N-1:0]  pend_q;
  logic [TRACK_W-1:0]  slot_q;
  logic                req_valid_q;
  logic                req_we_q;
  logic [AW-1:0]       req_addr_q;
  logic                done_q;
  logic                rf_we_q;
  logic [WIN_W-1:0]    rf_wwin_q;
  logic [ARCH_W-1:0]   rf_widx_q;
  logic [DW-1:0]       rf_wdata_q;

  logic [TRACK_N-1:0]  cur_map;
  logic                map_ld;
  logic                save_path;
  logic                step;
  logic [TRACK_N-1:0]  pick_vec;
  logic                pick_found;
  logic [TRACK_W-1:0]  pick_idx;

  assign map_ld    = (st_q == ST_RS_MAPW) && mem_rsp_valid;
  assign save_path = (st_q == ST_SV_MAP) || (st_q == ST_SV_REG);
  assign step      = (save_path && req_valid_q && mem_req_ready) ||
                     (((st_q == ST_RS_MAPW) || (st_q == ST_RS_REGW)) && mem_rsp_valid);
  assign pick_vec  = (st_q == ST_RS_MAPW) ? mem_rsp_data[TRACK_N-1:0] : pend_q;

  winsave_dirty_map #(
    .NWIN  (NWIN),
    .WIN_W (WIN_W)
  ) u_map (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (enter_en),
    .clr_win  (enter_win),
    .set_en   (wr_en && wr_idx[ARCH_W-1]),
    .set_win  (wr_win),
    .set_slot (arch_to_slot(wr_idx)),
    .ld_en    (map_ld),
    .ld_win   (win_q),
    .ld_map   (mem_rsp_data[TRACK_N-1:0]),
    .rd_win   (cmd_win),
    .rd_map   (cur_map)
  );

  winsave_pick #(
    .N (TRACK_N),
    .W (TRACK_W)
  ) u_pick (
    .vec   (pick_vec),
    .found (pick_found),
    .first (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      win_q       <= '0;
      base_q      <= '0;
      pend_q      <= '0;
      slot_q      <= '0;
      req_valid_q <= 1'b0;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      done_q      <= 1'b0;
      rf_we_q     <= 1'b0;
      rf_wwin_q   <= '0;
      rf_widx_q   <= '0;
      rf_wdata_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      rf_we_q <= 1'b0;

      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            win_q       <= cmd_win;
            base_q      <= cmd_base;
            req_valid_q <= 1'b1;
            req_we_q    <= cmd_save;
            req_addr_q  <= cmd_base;
            if (cmd_save) begin
              pend_q <= cur_map;
              st_q   <= ST_SV_MAP;
            end else begin
              st_q   <= ST_RS_MAP;
            end
          end
        end
        ST_RS_MAP: begin
          if (mem_req_ready) begin
            req_valid_q <= 1'b0;
            st_q        <= ST_RS_MAPW;
          end
        end
        ST_RS_REG: begin
          if (mem_req_ready) begin
            req_valid_q <= 1'b0;
            st_q        <= ST_RS_REGW;
          end
        end
        default: ;
      endcase

      if (st_q == ST_RS_REGW && mem_rsp_valid) begin
        rf_we_q    <= 1'b1;
        rf_wwin_q  <= win_q;
        rf_widx_q  <= slot_to_arch(slot_q);
        rf_wdata_q <= mem_rsp_data;
      end

      if (step) begin
        if (pick_found) begin
          slot_q      <= pick_idx;
          pend_q      <= pick_vec & ~(TRACK_N'(1) << pick_idx);
          req_valid_q <= 1'b1;
          req_we_q    <= save_path;
          req_addr_q  <= base_q + AW'(pick_idx) + AW'(1);
          st_q        <= save_path ? ST_SV_REG : ST_RS_REG;
        end else begin
          req_valid_q <= 1'b0;
          done_q      <= 1'b1;
          st_q        <= ST_IDLE;
        end
      end
    end
  end

  assign busy          = (st_q != ST_IDLE);
  assign done          = done_q;
  assign rf_rd_win     = win_q;
  assign rf_rd_idx     = slot_to_arch(slot_q);
  assign rf_we         = rf_we_q;
  assign rf_wwin       = rf_wwin_q;
  assign rf_widx       = rf_widx_q;
  assign rf_wdata      = rf_wdata_q;
  assign mem_req_valid = req_valid_q;
  assign mem_req_we    = req_we_q;
  assign mem_req_addr  = req_addr_q;
  assign mem_req_wdata = (st_q == ST_SV_MAP) ? {{(DW-TRACK_N){1'b0}}, pend_q} : rf_rd_data;

endmodule

// File: rtl/winsave_seq_chk.sv
module winsave_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_valid,
  input logic          rf_we
);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid);

  assert_rf_after_rsp_R7: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> ($past(mem_rsp_valid) && !$past(mem_req_we)));

endmodule

bind winsave_seq winsave_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/winsave_seq_tb.sv
module winsave_seq_tb;

  localparam int NWIN  = 8;
  localparam int WIN_W = 3;
  localparam int AW    = 16;
  localparam int DW    = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic             enter_en = 0, wr_en = 0, cmd_valid = 0, cmd_save = 0;
  logic [WIN_W-1:0] enter_win = '0, wr_win = '0, cmd_win = '0;
  logic [4:0]       wr_idx = '0;
  logic [AW-1:0]    cmd_base = '0;
  logic             busy, done, rf_we, mem_req_valid, mem_req_we;
  logic [WIN_W-1:0] rf_rd_win, rf_wwin;
  logic [4:0]       rf_rd_idx, rf_widx;
  logic [DW-1:0]    rf_rd_data, rf_wdata, mem_req_wdata;
  logic [AW-1:0]    mem_req_addr;
  logic             mem_req_ready = 0, mem_rsp_valid = 0;
  logic [DW-1:0]    mem_rsp_data = '0;

  winsave_seq #(.NWIN(NWIN), .AW(AW), .DW(DW)) u_dut (.*);

  // models
  logic [DW-1:0] rf_m  [NWIN][32];
  logic [DW-1:0] mem_m [256];
  logic [15:0]   map_m [NWIN];
  assign rf_rd_data = rf_m[rf_rd_win][rf_rd_idx];

  typedef struct packed { logic we; logic [AW-1:0] addr; logic [DW-1:0] data; } mreq_t;
  typedef struct packed { logic [WIN_W-1:0] win; logic [4:0] idx; logic [DW-1:0] data; } rfw_t;
  mreq_t mq[$];
  rfw_t  rq[$];

  int tests = 0, fails = 0, cyc = 0, last_evt = 0;
  string tag = "";
  bit stall = 0, ld_pend = 0, hold_v = 0;
  int ld_wait = 0;
  logic [7:0] ld_addr, lf = 8'h5a;
  logic [AW-1:0] hold_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s [%s] act=%h exp=%h", req, what, tag, act, exp);
    end
  endtask

  function automatic int slot_of(input int a);
    return (a >= 24) ? a - 24 : a - 8;
  endfunction
  function automatic int arch_of(input int t);
    return (t < 8) ? t + 24 : t + 8;
  endfunction

  // memory model and monitor
  always @(negedge clk) begin
    mreq_t e;
    rfw_t  r;
    cyc++;
    mem_rsp_valid = 1'b0;
    if (ld_pend) begin
      if (ld_wait == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_m[ld_addr];
        ld_pend = 0;
        last_evt = cyc;
      end else ld_wait--;
    end
    if (rf_we) begin
      if (rq.size() == 0) chk(0, "R7", "unexpected rf write", {27'd0, rf_widx}, '0);
      else begin
        r = rq.pop_front();
        chk(rf_wwin == r.win && rf_widx == r.idx, "R7", "rf write target",
            {24'd0, rf_wwin, rf_widx}, {24'd0, r.win, r.idx});
        chk(rf_wdata == r.data, "R7", "rf write data", rf_wdata, r.data);
      end
      rf_m[rf_wwin][rf_widx] = rf_wdata;
    end
    if (hold_v)
      chk(mem_req_valid && mem_req_addr == hold_addr, "R5", "request held",
          {16'd0, mem_req_addr}, {16'd0, hold_addr});
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    mem_req_ready = stall ? lf[0] : 1'b1;
    hold_v = mem_req_valid && !mem_req_ready;
    hold_addr = mem_req_addr;
    if (mem_req_valid && mem_req_ready) begin
      if (mq.size() == 0) chk(0, "R4", "unexpected request", {16'd0, mem_req_addr}, '0);
      else begin
        e = mq.pop_front();
        chk(mem_req_we == e.we && mem_req_addr == e.addr, "R4", "request dir/addr",
            {15'd0, mem_req_we, mem_req_addr}, {15'd0, e.we, e.addr});
        if (e.we) chk(mem_req_wdata == e.data, "R3", "store data", mem_req_wdata, e.data);
      end
      if (mem_req_we) begin
        mem_m[mem_req_addr[7:0]] = mem_req_wdata;
        last_evt = cyc;
      end else begin
        ld_pend = 1;
        ld_addr = mem_req_addr[7:0];
        ld_wait = stall ? int'(lf[1]) : 0;
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic snoop(input int w, input int a, input logic [DW-1:0] d);
    tick();
    wr_en = 1; wr_win = WIN_W'(w); wr_idx = 5'(a);
    rf_m[w][a] = d;
    if (a >= 16) map_m[w][slot_of(a)] = 1'b1;
    tick();
    wr_en = 0;
  endtask

  task automatic enter_and_write(input int w, input int a, input logic [DW-1:0] d);
    tick();
    enter_en = 1; enter_win = WIN_W'(w);
    wr_en = 1; wr_win = WIN_W'(w); wr_idx = 5'(a);
    rf_m[w][a] = d;
    map_m[w] = '0;
    map_m[w][slot_of(a)] = 1'b1;
    tick();
    enter_en = 0; wr_en = 0;
  endtask

  task automatic run_cmd(input bit sv, input int w, input int base, input bit poke);
    tick();
    cmd_valid = 1; cmd_save = sv; cmd_win = WIN_W'(w); cmd_base = AW'(base);
    tick();
    if (poke) begin
      chk(busy == 1'b1, "R10", "busy while running", {31'd0, busy}, 1);
      cmd_save = ~sv; cmd_win = WIN_W'(w + 1); cmd_base = AW'(8'hF0);
      tick();
    end
    cmd_valid = 0;
    while (!done) tick();
    chk(cyc == last_evt + 1, "R9", "done one cycle after last transfer", cyc, last_evt + 1);
    chk(mq.size() == 0, "R4", "all expected requests issued", mq.size(), 0);
    tick();
    chk(done == 1'b0 && busy == 1'b0, "R9", "done single pulse, idle",
        {30'd0, done, busy}, 0);
    repeat (3) tick();
    chk(mem_req_valid == 1'b0, "R10", "no request after command", {31'd0, mem_req_valid}, 0);
  endtask

  task automatic do_save(input int w, input int base, input bit poke);
    mreq_t e;
    e.we = 1; e.addr = AW'(base); e.data = {16'd0, map_m[w]};
    mq.push_back(e);
    for (int t = 0; t < 16; t++)
      if (map_m[w][t]) begin
        e.addr = AW'(base + 1 + t); e.data = rf_m[w][arch_of(t)];
        mq.push_back(e);
      end
    run_cmd(1, w, base, poke);
  endtask

  task automatic do_restore(input int w, input int base);
    mreq_t e;
    rfw_t r;
    logic [15:0] m;
    logic [DW-1:0] expv [32];
    m = mem_m[base][15:0];
    for (int a = 0; a < 32; a++) expv[a] = rf_m[w][a];
    e.we = 0; e.addr = AW'(base); e.data = '0;
    mq.push_back(e);
    for (int t = 0; t < 16; t++)
      if (m[t]) begin
        e.addr = AW'(base + 1 + t);
        mq.push_back(e);
        r.win = WIN_W'(w); r.idx = 5'(arch_of(t)); r.data = mem_m[base + 1 + t];
        rq.push_back(r);
        expv[arch_of(t)] = mem_m[base + 1 + t];
      end
    map_m[w] = m;
    run_cmd(0, w, base, 0);
    chk(rq.size() == 0, "R7", "all restore writes seen", rq.size(), 0);
    for (int a = 0; a < 32; a++)
      chk(rf_m[w][a] == expv[a], "R7", $sformatf("rf content idx %0d", a), rf_m[w][a], expv[a]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int w = 0; w < NWIN; w++) begin
      map_m[w] = '0;
      for (int a = 0; a < 32; a++) rf_m[w][a] = {8'hA0, 8'(w), 8'(a), 8'h5C};
    end
    for (int i = 0; i < 256; i++) mem_m[i] = {16'hDEAD, 16'(i)};
    repeat (3) tick();
    rst = 0;
    tick();
    tag = "reset";
    chk(busy == 0 && done == 0 && mem_req_valid == 0 && rf_we == 0, "R11", "idle after reset",
        {28'd0, busy, done, mem_req_valid, rf_we}, 0);

    tag = "untouched window";     // R11 zero record, R9 single store
    do_save(5, 'h10, 0);

    tag = "mixed writes, stalls"; // R2 ignored globals/outs, R3, R4, R5
    stall = 1;
    snoop(2, 24, 32'h1111_0000);
    snoop(2, 31, 32'h1111_0007);
    snoop(2, 16, 32'h1111_0010);
    snoop(2, 23, 32'h1111_0017);
    snoop(2, 3,  32'h2222_0003);
    snoop(2, 12, 32'h2222_000C);
    chk(map_m[2] == 16'h8181, "R2", "bench record", {16'd0, map_m[2]}, 32'h8181);
    do_save(2, 'h20, 0);
    stall = 0;

    tag = "entry+write same cycle"; // R1, R2
    snoop(2, 26, 32'h3333_0002);
    enter_and_write(2, 20, 32'h4444_0014);
    do_save(2, 'h40, 0);

    tag = "entry clears";           // R1
    snoop(6, 25, 32'h5555_0001);
    enter_and_write(1, 17, 32'h0);
    tick(); enter_en = 1; enter_win = 3'd6; tick(); enter_en = 0; map_m[6] = '0;
    do_save(6, 'h60, 0);

    tag = "restore marked slots";   // R6, R7, R8
    snoop(3, 29, 32'h6666_0005);
    snoop(3, 9,  32'h6666_0009);
    stall = 1;
    do_restore(3, 'h20);
    stall = 0;
    do_save(3, 'h70, 0);            // R8 reproduces 0x8181

    tag = "zero-header restore";    // R6, R9
    do_restore(4, 'h10);

    tag = "full record";            // R4 ascending over all 16
    for (int t = 0; t < 16; t++) snoop(6, arch_of(t), 32'h7700_0000 + t);
    stall = 1;
    do_save(6, 'hA0, 0);
    do_restore(7, 'hA0);
    stall = 0;

    tag = "busy command";           // R10
    snoop(2, 30, 32'h8888_0006);
    do_save(2, 'h80, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule